// File: doc/BRIEF.md
# Eight-Function Arithmetic/Logic Unit with Zero Detect

This block is the purely combinational arithmetic/logic unit of a small load/store processor datapath. It takes two 32-bit operands and a 3-bit function select. From these it produces a 32-bit result and a flag that is high when that result is zero. No register sits between the inputs and the outputs, so the result settles in the same cycle that the operands arrive.

The surrounding datapath chooses what drives the second operand: a register value or an extended immediate. Branch logic watches the zero flag. The functions are:

- wrapping add and subtract;
- signed and unsigned set-less-than;
- AND, OR and NOR;
- an upper-immediate function that moves operand B into the upper half of the word.

Top module: `alu8_zf`

## Requirements
- R1: Select 3'd0 drives `result` with (op_a + op_b) mod 2^32, with no overflow indication of any kind.
- R2: Select 3'd1 drives `result` with (op_a - op_b) mod 2^32, wrapping on borrow.
- R3: Select 3'd2 compares op_a and op_b as signed two's-complement numbers. `result` is 1 when op_a < op_b and 0 otherwise.
- R4: Select 3'd3 compares op_a and op_b as unsigned numbers. `result` is 1 when op_a < op_b and 0 otherwise.
- R5: Select 3'd4 drives `result` with the bitwise AND of the operands.
- R6: Select 3'd5 drives `result` with the bitwise OR of the operands.
- R7: Select 3'd7 drives `result` with the bitwise NOR of the operands.
- R8: Select 3'd6 drives `result` with op_b shifted left by 16 bit positions, and bits 15:0 are zero. The value of op_a has no effect on `result` or `is_zero` under this select.
- R9: `is_zero` is 1 exactly when all 32 bits of `result` are 0, under every select value.
- R10: Under selects 3'd2 and 3'd3, the comparison outcome sits in bit 0 and bits 31:1 of `result` are always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand (register value or extended immediate) |
| fn_sel | input | 3 | Function select, encoding as in R1 to R8 |
| result | output | 32 | Function output |
| is_zero | output | 1 | High when `result` is all zeros |

## Verification
The block holds no state. A fault therefore shows up at the ports in the same evaluation that applies the triggering operands, and it stays visible only as long as those operands are held. Because of this, every vector is checked right after it settles.

The faults most likely to slip through are those that only show at boundaries:

- a signed compare swapped with an unsigned one, which differs only when exactly one operand has bit 31 set;
- a shift with the wrong amount;
- a zero flag that follows the wrong select.

Directed vectors target each of these. Random vectors then compare every select against an independent model in the bench.

// File: rtl/alu8_zf.sv
module alu8_zf #(
  parameter int WIDTH = 32,
  parameter int SEL_W = 3
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [SEL_W-1:0] fn_sel,
  output logic [WIDTH-1:0] result,
  output logic             is_zero
);

  localparam int HALF = WIDTH / 2;

  logic [WIDTH-1:0] sum_w, dif_w, upper_w;
  logic             lt_s, lt_u;

  assign sum_w   = op_a + op_b;
  assign dif_w   = op_a - op_b;
  assign lt_u    = op_a < op_b;
  assign lt_s    = (op_a[WIDTH-1] != op_b[WIDTH-1]) ? op_a[WIDTH-1] : lt_u;
  assign upper_w = {op_b[WIDTH-HALF-1:0], {HALF{1'b0}}};

  always_comb begin
    case (fn_sel)
      3'd0:    result = sum_w;
      3'd1:    result = dif_w;
      3'd2:    result = {{(WIDTH-1){1'b0}}, lt_s};
      3'd3:    result = {{(WIDTH-1){1'b0}}, lt_u};
      3'd4:    result = op_a & op_b;
      3'd5:    result = op_a | op_b;
      3'd6:    result = upper_w;
      default: result = ~(op_a | op_b);
    endcase
  end

  assign is_zero = ~|result;

endmodule

// File: rtl/alu8_zf_chk.sv
module alu8_zf_chk #(
  parameter int WIDTH = 32,
  parameter int SEL_W = 3
) (
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic [SEL_W-1:0] fn_sel,
  input logic [WIDTH-1:0] result,
  input logic             is_zero
);

  always_comb begin
    if (!$isunknown({op_a, op_b, fn_sel})) begin
      if (fn_sel == 3'd0) a_r1_add_inverse: assert (result - op_b == op_a);
      if (fn_sel == 3'd1) a_r2_sub_inverse: assert (result + op_b == op_a);
      if (fn_sel == 3'd4) a_r5_and_subset: assert ((result & ~op_a) == '0);
      if (fn_sel == 3'd5) a_r6_or_superset: assert ((op_a & ~result) == '0);
      if (fn_sel == 3'd7) a_r7_nor_disjoint: assert ((result & (op_a | op_b)) == '0);
      if (fn_sel == 3'd6) a_r8_low_half_clear: assert (result[15:0] == '0);
      if (fn_sel == 3'd2 || fn_sel == 3'd3) a_r10_flag_only: assert (result[WIDTH-1:1] == '0);
      if (fn_sel == 3'd1 && op_a == op_b) a_r9_equal_sub_zero: assert (is_zero);
      if (fn_sel == 3'd5 && op_a != '0) a_r9_or_nonzero: assert (!is_zero);
    end
  end

endmodule

bind alu8_zf alu8_zf_chk #(.WIDTH(WIDTH), .SEL_W(SEL_W)) chk_i (
  .op_a(op_a), .op_b(op_b), .fn_sel(fn_sel), .result(result), .is_zero(is_zero)
);

// File: tb/alu8_zf_tb_top.sv
module alu8_zf_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] a, b;
  logic [2:0]  sel;
  logic [31:0] res;
  logic        zf;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  alu8_zf dut_i (.op_a(a), .op_b(b), .fn_sel(sel), .result(res), .is_zero(zf));

  function automatic logic [31:0] model(input logic [2:0] s, input logic [31:0] x, input logic [31:0] y);
    case (s)
      3'd0: return x + y;
      3'd1: return x - y;
      3'd2: return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
      3'd3: return (x < y) ? 32'd1 : 32'd0;
      3'd4: return x & y;
      3'd5: return x | y;
      3'd6: return y * 32'd65536;
      default: return ~(x | y);
    endcase
  endfunction

  task automatic apply(input logic [2:0] s, input logic [31:0] x, input logic [31:0] y, input string req);
    logic [31:0] exp_r;
    @(negedge clk);
    sel = s; a = x; b = y;
    #5;
    exp_r = model(s, x, y);
    n_chk++;
    if (res !== exp_r || zf !== (exp_r == 32'd0)) begin
      n_bad++;
      $display("FAIL %s sel=%0d a=%h b=%h: got res=%h z=%b, expected res=%h z=%b",
               req, s, x, y, res, zf, exp_r, exp_r == 32'd0);
    end
  endtask

  task automatic t_reset_state;
    @(negedge clk);
    n_chk++;
    if (res !== 32'h0000_0000 || zf !== 1'b1) begin
      n_bad++;
      $display("FAIL R9 idle: got res=%h z=%b, expected res=00000000 z=1", res, zf);
    end
  endtask

  task automatic t_arith;
    apply(3'd0, 32'hFFFF_FFFF, 32'h0000_0001, "R1");
    apply(3'd0, 32'h7FFF_FFFF, 32'h0000_0001, "R1");
    apply(3'd0, 32'h1234_5678, 32'h1111_1111, "R1");
    apply(3'd1, 32'h0000_0000, 32'h0000_0001, "R2");
    apply(3'd1, 32'h8000_0000, 32'h0000_0001, "R2");
    apply(3'd1, 32'hDEAD_BEEF, 32'hDEAD_BEEF, "R2 R9");
  endtask

  task automatic t_compare;
    apply(3'd2, 32'hFFFF_FFFF, 32'h0000_0001, "R3");
    apply(3'd2, 32'h0000_0001, 32'hFFFF_FFFF, "R3");
    apply(3'd2, 32'h8000_0000, 32'h7FFF_FFFF, "R3");
    apply(3'd2, 32'h0000_0005, 32'h0000_0005, "R3 R10");
    apply(3'd3, 32'hFFFF_FFFF, 32'h0000_0001, "R4");
    apply(3'd3, 32'h0000_0001, 32'hFFFF_FFFF, "R4 R10");
    apply(3'd3, 32'h7FFF_FFFF, 32'h8000_0000, "R4");
    apply(3'd3, 32'h0000_0000, 32'h0000_0000, "R4 R9");
  endtask

  task automatic t_logic;
    apply(3'd4, 32'hF0F0_F0F0, 32'h0F0F_0F0F, "R5 R9");
    apply(3'd4, 32'hFFFF_0000, 32'hFF00_FF00, "R5");
    apply(3'd5, 32'hF0F0_0000, 32'h0000_0F0F, "R6");
    apply(3'd5, 32'h0000_0000, 32'h0000_0000, "R6 R9");
    apply(3'd7, 32'h0000_0000, 32'h0000_0000, "R7");
    apply(3'd7, 32'hFFFF_0000, 32'h0000_FFFF, "R7 R9");
  endtask

  task automatic t_upper;
    apply(3'd6, 32'h0000_0000, 32'h0000_0064, "R8");
    apply(3'd6, 32'hFFFF_FFFF, 32'h0000_0064, "R8 op_a ignored");
    apply(3'd6, 32'h1234_5678, 32'hABCD_0000, "R8 R9");
    apply(3'd6, 32'h0000_0000, 32'h0001_8001, "R8");
  endtask

  task automatic t_random;
    for (int i = 0; i < 400; i++) begin
      logic [31:0] x, y;
      x = $urandom;
      y = (i % 4 == 0) ? x : $urandom;
      apply(3'(i % 8), x, y, "R1..R10 random");
    end
  endtask

  initial begin
    sel = 3'd4; a = '0; b = '0;
    repeat (2) @(posedge clk);
    rst = 1'b0;
    t_reset_state();
    t_arith();
    t_compare();
    t_logic();
    t_upper();
    t_random();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule